// File: doc/BRIEF.md
# Coalescing Interrupt Cause Controller

This block gathers interrupt causes raised inside a device into a 32-bit cause register, gates them with a 32-bit enable mask, and drives a single host interrupt line. Each cause bit is set by a one-cycle pulse from an internal source. It stays set until the host writes a one to that bit position. Writing a zero to a cause bit leaves it as it is.

The host line does not follow the masked causes directly. A hold-off timer, counted in 32-microsecond units, starts when the first enabled cause becomes pending. The line rises only when that timer expires, so events that arrive close together lead to a single interrupt. A high-priority receive pulse skips the hold-off and raises the line at once. A separate periodic generator sets the receive-periodic cause at a programmable interval. The length of one unit in clock cycles is a parameter.

The register bus has a write strobe, a word address, 32-bit write data and per-byte enables. Reads are combinational.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the cause register (word address 0) reads 0, the mask register (word address 1) reads 0, the hold-off control register (word address 2) reads 0x0000_0040, and `irq_out` is low.
- R2: A pulse on `evt_set[b]` sets cause bit b at the next clock edge. A bus write to address 0 clears each cause bit whose write-data bit is one and whose byte enable is set. Cause bits written with zero do not change.
- R3: If a set pulse and a host clear hit the same cause bit in the same cycle, the bit ends up set.
- R4: Only causes whose mask bit is one can assert `irq_out` or start the hold-off timer. A pending cause that is masked off leaves `irq_out` low.
- R5: Byte 0 of address 2 is the hold-off delay D, in units. For D greater than 0, `irq_out` rises exactly D×CYC_PER_UNIT clock edges after the edge that captured the first enabled pending cause, and stays low until then.
- R6: With D equal to 0, `irq_out` is high in the cycle that follows the edge that captured the enabled cause.
- R7: `irq_out` drops as soon as no enabled cause is pending. It stays high while any enabled cause remains pending. The next enabled cause after that starts a full new hold-off.
- R8: A pulse on `hipri_rx` sets cause bit 31 (receive DMA). If mask bit 31 is one, `irq_out` is high after that same edge, whatever the delay is.
- R9: Byte 1 of address 2 is the periodic interval V. A nonzero V sets cause bit 28 every V×CYC_PER_UNIT clock cycles, counted from the edge that wrote V. A V of 0 stops the periodic setting of bit 28.
- R10: Writes to address 2 obey the byte enables. Writing only byte 1 leaves the delay unchanged, and writing only byte 0 leaves the interval unchanged. Bits 31:16 of address 2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 cause, 1 mask, 2 hold-off control |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_set | input | 32 | Per-bit cause set pulses from device sources |
| hipri_rx | input | 1 | High-priority receive pulse (sets bit 31, bypasses hold-off) |
| irq_out | output | 1 | Host interrupt line |

## Verification
The write-one-to-clear path is swept over all 32 bit positions. Each position gets a write of zeros and then a write of a one, which separates "unchanged" from "cleared" and exposes any cross-bit leakage. The hold-off delay is swept from 0 to 5 units, with the line sampled one cycle before and exactly at the expected edge. This catches off-by-one-tick errors and a missing zero-delay path, and repeating the sweep after each acknowledge shows that the timer re-arms. Further directed patterns cover a masked cause paired with an enabled one, a set and clear that collide in the same cycle, the bypass with bit 31 enabled and disabled, and periodic intervals with byte-lane writes. Together these separate the set priority, the mask gating and the lane isolation.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned ADDR_W  = 2;

    localparam int unsigned BIT_RX_DMA   = 31;
    localparam int unsigned BIT_HW_ERR   = 29;
    localparam int unsigned BIT_RX_TICK  = 28;
    localparam int unsigned BIT_ALIVE    = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_CAUSE = 2'd0,
        REG_MASK  = 2'd1,
        REG_HOLD  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] interval;
        logic [7:0] delay;
    } hold_cfg_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [LANES-1:0]  be);
        logic [DATA_W-1:0] m;
        m = lane_mask(be);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/irqc_unit_tick.sv
module irqc_unit_tick #(
    parameter int unsigned CYC_PER_UNIT = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (CYC_PER_UNIT > 1) ? $clog2(CYC_PER_UNIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_UNIT - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/irqc_holdoff.sv
module irqc_holdoff #(
    parameter int unsigned CYC_PER_UNIT = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pending,
    input  logic       bypass,
    input  logic [7:0] delay,
    output logic       fire
);
    logic       armed;
    logic       tick;
    logic       expire;
    logic [7:0] units;

    assign armed  = pending && !fire && (delay != 8'd0);
    assign expire = armed && tick && (units == delay - 8'd1);

    irqc_unit_tick #(.CYC_PER_UNIT(CYC_PER_UNIT)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (armed),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            units <= '0;
        end else if (tick) begin
            units <= units + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fire <= 1'b0;
        end else if (expire || bypass) begin
            fire <= 1'b1;
        end else if (!pending) begin
            fire <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_periodic.sv
module irqc_periodic #(
    parameter int unsigned CYC_PER_UNIT = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] interval,
    input  logic       restart,
    output logic       pulse
);
    logic       run;
    logic       tick;
    logic [7:0] units;

    assign run   = (interval != 8'd0) && !restart;
    assign pulse = run && tick && (units == interval - 8'd1);

    irqc_unit_tick #(.CYC_PER_UNIT(CYC_PER_UNIT)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !run || pulse) begin
            units <= '0;
        end else if (tick) begin
            units <= units + 8'd1;
        end
    end
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter logic [7:0] DELAY_RESET = 8'h40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [LANES-1:0]    be,
    input  logic [DATA_W-1:0]   set_vec,
    output logic [DATA_W-1:0]   cause,
    output logic [DATA_W-1:0]   mask,
    output hold_cfg_t           cfg,
    output logic                interval_wr,
    output logic [DATA_W-1:0]   rdata
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] cfg_next;

    assign sel         = reg_sel_e'(addr);
    assign clr_vec     = (wr && sel == REG_CAUSE) ? (wdata & lane_mask(be)) : '0;
    assign cfg_word    = {16'd0, cfg};
    assign cfg_next    = lane_merge(cfg_word, wdata, be);
    assign interval_wr = wr && (sel == REG_HOLD) && be[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= '0;
        end else begin
            cause <= (cause & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            cfg  <= '{interval: 8'd0, delay: DELAY_RESET};
        end else if (wr) begin
            if (sel == REG_MASK) begin
                mask <= lane_merge(mask, wdata, be);
            end
            if (sel == REG_HOLD) begin
                cfg <= hold_cfg_t'(cfg_next[15:0]);
            end
        end
    end

    always_comb begin
        case (sel)
            REG_CAUSE: rdata = cause;
            REG_MASK:  rdata = mask;
            REG_HOLD:  rdata = cfg_word;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
    import irqc_pkg::*;
#(
    parameter int unsigned CYC_PER_UNIT = 4000,
    parameter logic [7:0]  DELAY_RESET  = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       evt_set,
    input  logic              hipri_rx,
    output logic              irq_out
);
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] set_vec;
    hold_cfg_t         cfg;
    logic              interval_wr;
    logic              tick_pulse;
    logic              pending;
    logic              bypass;
    logic              fire;

    always_comb begin
        set_vec = evt_set;
        set_vec[BIT_RX_DMA]  = set_vec[BIT_RX_DMA]  | hipri_rx;
        set_vec[BIT_RX_TICK] = set_vec[BIT_RX_TICK] | tick_pulse;
    end

    irqc_regfile #(.DELAY_RESET(DELAY_RESET)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .be          (bus_be),
        .set_vec     (set_vec),
        .cause       (cause_q),
        .mask        (mask_q),
        .cfg         (cfg),
        .interval_wr (interval_wr),
        .rdata       (bus_rdata)
    );

    irqc_periodic #(.CYC_PER_UNIT(CYC_PER_UNIT)) u_periodic (
        .clk      (clk),
        .rst      (rst),
        .interval (cfg.interval),
        .restart  (interval_wr),
        .pulse    (tick_pulse)
    );

    assign pending = |(cause_q & mask_q);
    assign bypass  = hipri_rx && mask_q[BIT_RX_DMA];

    irqc_holdoff #(.CYC_PER_UNIT(CYC_PER_UNIT)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .bypass  (bypass),
        .delay   (cfg.delay),
        .fire    (fire)
    );

    assign irq_out = pending && (fire || (cfg.delay == 8'd0));
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [31:0] evt_set,
    input logic        hipri_rx,
    input logic [31:0] cause_q,
    input logic [31:0] mask_q,
    input logic        irq_out
);
    // R2: a cause bit only rises when its source pulsed (bits 28/31 have extra sources)
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        ((cause_q & ~$past(cause_q) & ~$past(evt_set) & ~32'h9000_0000) == 32'd0));

    // R3: a set pulse always lands, even against a host clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_set != 32'd0) |=> ((cause_q & $past(evt_set)) == $past(evt_set)));

    // R4: the line needs an enabled pending cause
    a_r4_needs_enabled: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((cause_q & mask_q) != 32'd0));

    // R8: enabled high-priority receive raises the line after its edge
    a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
        (hipri_rx && mask_q[31] && !bus_wr) |=> irq_out);
endmodule

bind irq_coalesce irqc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .evt_set  (evt_set),
    .hipri_rx (hipri_rx),
    .cause_q  (cause_q),
    .mask_q   (mask_q),
    .irq_out  (irq_out)
);

// File: tb/irq_coalesce_test.sv
`timescale 1ns/1ps
module irq_coalesce_test;
    localparam int unsigned P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_rdata;
    logic [31:0] evt_set = 32'd0;
    logic        hipri_rx = 1'b0;
    logic        irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_coalesce #(.CYC_PER_UNIT(P)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .hipri_rx(hipri_rx), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = 32'd0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check(d == 32'd0, "R1 cause", d, 32'd0);
        rd(2'd1, d); check(d == 32'd0, "R1 mask", d, 32'd0);
        rd(2'd2, d); check(d == 32'h40, "R1 hold", d, 32'h40);
        check(irq_out == 1'b0, "R1 irq", {31'd0, irq_out}, 32'd0);

        // R2 set and write-one-to-clear on every bit, masked off so R4 holds
        for (int b = 0; b < 32; b++) begin
            pulse(32'd1 << b);
            rd(2'd0, d); check(d == (32'd1 << b), "R2 set", d, 32'd1 << b);
            wr(2'd0, ~(32'd1 << b) & 32'd0, 4'hF);
            wr(2'd0, ~(32'd1 << b), 4'hF);
            rd(2'd0, d); check(d == (32'd1 << b), "R2 zero-write keeps", d, 32'd1 << b);
            check(irq_out == 1'b0, "R4 masked bit", {31'd0, irq_out}, 32'd0);
            wr(2'd0, 32'd1 << b, 4'hF);
            rd(2'd0, d); check(d == 32'd0, "R2 clear", d, 32'd0);
        end

        // R3 set and clear in the same cycle
        @(negedge clk);
        evt_set = 32'h20; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h20;
        @(negedge clk);
        evt_set = 32'd0; bus_wr = 1'b0; bus_wdata = 32'd0;
        rd(2'd0, d); check(d == 32'h20, "R3 set wins", d, 32'h20);
        wr(2'd0, 32'h20, 4'hF);

        // R4 mask gating, R6 zero delay
        wr(2'd2, 32'h0, 4'h1);
        wr(2'd1, 32'h8, 4'hF);
        pulse(32'h80);
        check(irq_out == 1'b0, "R4 masked pending", {31'd0, irq_out}, 32'd0);
        pulse(32'h8);
        check(irq_out == 1'b1, "R6 zero delay", {31'd0, irq_out}, 32'd1);
        wr(2'd0, 32'h8, 4'hF);
        check(irq_out == 1'b0, "R4 only masked left", {31'd0, irq_out}, 32'd0);
        wr(2'd0, 32'h80, 4'hF);

        // R5/R6/R7 delay sweep with re-arm
        wr(2'd1, 32'h1, 4'hF);
        for (int dl = 0; dl <= 5; dl++) begin
            wr(2'd2, dl, 4'h1);
            repeat (2) @(negedge clk);
            pulse(32'h1);
            for (int k = 0; k <= dl * P; k++) begin
                if (k == dl * P)
                    check(irq_out == 1'b1, "R5 rise at D*P", {31'd0, irq_out}, 32'd1);
                else if (k == dl * P - 1)
                    check(irq_out == 1'b0, "R5 low before D*P", {31'd0, irq_out}, 32'd0);
                if (k < dl * P) @(negedge clk);
            end
            wr(2'd0, 32'h1, 4'hF);
            check(irq_out == 1'b0, "R7 drop after ack", {31'd0, irq_out}, 32'd0);
        end

        // R7 two enabled causes
        wr(2'd1, 32'h3, 4'hF);
        wr(2'd2, 32'h0, 4'h1);
        pulse(32'h3);
        wr(2'd0, 32'h1, 4'hF);
        check(irq_out == 1'b1, "R7 stays with one pending", {31'd0, irq_out}, 32'd1);
        wr(2'd0, 32'h2, 4'hF);
        check(irq_out == 1'b0, "R7 drops when none", {31'd0, irq_out}, 32'd0);

        // R8 bypass
        wr(2'd2, 32'hFF, 4'h1);
        wr(2'd1, 32'h8000_0000, 4'hF);
        @(negedge clk); hipri_rx = 1'b1; @(negedge clk); hipri_rx = 1'b0;
        check(irq_out == 1'b1, "R8 bypass", {31'd0, irq_out}, 32'd1);
        rd(2'd0, d); check(d == 32'h8000_0000, "R8 bit31", d, 32'h8000_0000);
        wr(2'd0, 32'h8000_0000, 4'hF);
        wr(2'd1, 32'h0, 4'hF);
        @(negedge clk); hipri_rx = 1'b1; @(negedge clk); hipri_rx = 1'b0;
        check(irq_out == 1'b0, "R8 masked bypass", {31'd0, irq_out}, 32'd0);
        rd(2'd0, d); check(d == 32'h8000_0000, "R8 bit31 masked", d, 32'h8000_0000);
        wr(2'd0, 32'h8000_0000, 4'hF);

        // R9 periodic, interval 2, written through byte 1 only (R10)
        wr(2'd2, 32'h0000_0200, 4'h2);
        for (int k = 0; k <= 2 * P; k++) begin
            rd(2'd0, d);
            if (k == 2 * P - 1) check(d[28] == 1'b0, "R9 not yet", d, 32'd0);
            if (k == 2 * P)     check(d[28] == 1'b1, "R9 periodic set", d, 32'h1000_0000);
            if (k < 2 * P) @(negedge clk);
        end
        rd(2'd2, d); check(d == 32'h0000_02FF, "R10 delay kept", d, 32'h0000_02FF);
        wr(2'd2, 32'h0000_0000, 4'h2);
        wr(2'd0, 32'h1000_0000, 4'hF);
        repeat (40) @(negedge clk);
        rd(2'd0, d); check(d == 32'd0, "R9 disabled", d, 32'd0);
        wr(2'd2, 32'hFFFF_AB11, 4'h1);
        rd(2'd2, d); check(d == 32'h0000_0011, "R10 byte0 only", d, 32'h0000_0011);
        wr(2'd2, 32'hFFFF_0000, 4'hF);
        rd(2'd2, d); check(d == 32'd0, "R10 upper zero", d, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule